// File: doc/BRIEF.md
# Nested two-stage address walker

This block turns a 32-bit guest linear address into a host physical address. Two translation levels are stacked. The guest owns a two-level page table: a directory, then a table, then the offset inside the page. The hypervisor owns a flat second-stage map, which gives the host page for every guest-physical page. Each guest-physical page number the guest walk produces is passed through the second-stage map before it is used. That covers the page the guest root register points at, the page a directory entry names and the page a table entry names.

A request carries the linear address. The guest root register, the second-stage base and the map-enable flag are sampled at the moment the request is accepted. A hypervisor sets the enable flag while a guest runs and clears it otherwise. With the flag clear, guest-physical addresses are used as host addresses without translation. Nothing is cached, so every request reads all of its entries from memory again. The walker serves one request at a time, through a single valid/ready read port. It returns either a host address or a fault code that names the stage and the level that failed.

Top module: `nested_xlate_walker`

## Requirements
- R1: After reset, `xl_req_ready` is 1, and `xl_rsp_valid` and `rd_req_valid` are 0.
- R2: The linear address splits into a directory index (bits 31:22), a table index (bits 21:12) and a page offset (bits 11:0). A guest entry is 4 bytes and sits at byte address page base + index*4. Bit 0 of a guest entry is the present bit, and bits 31:12 hold the next guest-physical page number. A read returns the aligned 64-bit word. Bits 31:0 of that word are used when address bit 2 is 0, and bits 63:32 when it is 1. The offset is passed through to the result unchanged.
- R3: A second-stage entry for guest page number G is 8 bytes, at byte address `host_map_base + G*8`. Bit 0 is the present bit, and bits HPA_W-1:12 hold the host page number.
- R4: With the map enabled, a walk makes exactly five reads, in this order: map(root page), directory entry, map(table page), table entry, map(data page).
- R5: With the map disabled, a walk makes exactly two reads, directory entry then table entry, and guest-physical page numbers are used as host page numbers.
- R6: A non-present entry ends the walk with `xl_rsp_fault`=1 and `xl_rsp_hpa`=0. The fault codes are 3'b010 for the guest directory and 3'b001 for the guest table. For the second stage they are 3'b100 when mapping the root page, 3'b101 when mapping the table page and 3'b110 when mapping the data page. On success the code is 3'b000.
- R7: No read is issued after a fault. The read count is 1 for 100, 2 for 010 (map enabled), 1 for 010 (map disabled), 3 for 101, 4 for 001 (map enabled), 2 for 001 (map disabled) and 5 for 110.
- R8: The root, the base and the enable flag are sampled when a request is accepted, and later changes do not affect that walk. Entries are read again on every request, so a table edited between requests changes the next result.
- R9: `xl_req_ready` stays 0 from acceptance until the response is taken. The response holds steady while `xl_rsp_ready` is 0.
- R10: A read request keeps its address while stalled, and at most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xl_req_valid | input | 1 | Translation request valid |
| xl_req_ready | output | 1 | Walker idle, can accept a request |
| xl_req_gla | input | GPA_W | Guest linear address |
| guest_dir_base | input | GPA_W | Guest root: guest-physical address of the directory (bits 11:0 ignored) |
| host_map_base | input | HPA_W | Host address of the second-stage map |
| map_enable | input | 1 | Second-stage translation on |
| xl_rsp_valid | output | 1 | Result valid |
| xl_rsp_ready | input | 1 | Result taken |
| xl_rsp_fault | output | 1 | Walk ended in a fault |
| xl_rsp_code | output | 3 | Fault stage and level |
| xl_rsp_hpa | output | HPA_W | Host physical address (0 on fault) |
| rd_req_valid | output | 1 | Memory read request valid |
| rd_req_ready | input | 1 | Memory accepts the read |
| rd_req_addr | output | HPA_W | Byte address of the entry |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | MEM_DW | Aligned 64-bit read data |

## Verification
The bench places a non-present entry at each of the five points in the walk, with the map both enabled and disabled. A walker that numbers the levels wrongly reports the wrong code. One that keeps going after a fault shows extra reads. The enabled walk checks every read address. A design that skipped mapping the root or a pointer, or that took the wrong half of the 64-bit word, would read from the wrong place. The bench edits tables and the root between requests to catch stale reuse. It changes the root, base and enable flag in the middle of a walk, and stalls both handshakes, to catch inputs that are not latched and responses or read addresses that drift.

// File: rtl/nxw_pkg.sv
package nxw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_S2_REQ,
    ST_S2_WAIT,
    ST_G_REQ,
    ST_G_WAIT,
    ST_DONE
  } walk_state_e;

  localparam logic [2:0] FC_NONE    = 3'b000;
  localparam logic [2:0] FC_G_TBL   = 3'b001;
  localparam logic [2:0] FC_G_DIR   = 3'b010;
  localparam logic [2:0] FC_S2_ROOT = 3'b100;
  localparam logic [2:0] FC_S2_TBL  = 3'b101;
  localparam logic [2:0] FC_S2_DATA = 3'b110;

  // phase: 0 = root/directory step, 1 = table step, 2 = data page step
  function automatic logic [2:0] s2_fault_code(input logic [1:0] ph);
    return {1'b1, ph};
  endfunction

  function automatic logic [2:0] guest_fault_code(input logic [1:0] ph);
    return (ph == 2'd0) ? FC_G_DIR : FC_G_TBL;
  endfunction

endpackage

// File: rtl/nxw_addr_gen.sv
module nxw_addr_gen #(
  parameter int HPA_W      = 40,
  parameter int GPA_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic [HPA_W-1:0]                    map_base,
  input  logic [GPA_W-PAGE_SHIFT-1:0]         gfn,
  input  logic [HPA_W-PAGE_SHIFT-1:0]         hfn,
  input  logic [(GPA_W-PAGE_SHIFT)/2-1:0]     idx,
  output logic [HPA_W-1:0]                    s2_addr,
  output logic [HPA_W-1:0]                    g_addr
);
  localparam int GFN_W   = GPA_W - PAGE_SHIFT;
  localparam int S2_ESH  = 3;  // 8-byte second-stage entries
  localparam int G_ESH   = 2;  // 4-byte guest entries
  localparam int S2_PAD  = HPA_W - GFN_W - S2_ESH;

  always_comb begin
    s2_addr = map_base + {{S2_PAD{1'b0}}, gfn, {S2_ESH{1'b0}}};
    g_addr  = {hfn, idx, {G_ESH{1'b0}}};
  end
endmodule

// File: rtl/nxw_entry_dec.sv
module nxw_entry_dec #(
  parameter int HPA_W      = 40,
  parameter int GPA_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MEM_DW     = 64
) (
  input  logic [MEM_DW-1:0]             rdata,
  input  logic                          lane_hi,
  output logic                          s2_present,
  output logic [HPA_W-PAGE_SHIFT-1:0]   s2_hfn,
  output logic                          g_present,
  output logic [GPA_W-PAGE_SHIFT-1:0]   g_gfn
);
  localparam int HALF = MEM_DW / 2;

  logic [HALF-1:0] word;
  logic            unused_bits;

  always_comb begin
    word       = lane_hi ? rdata[MEM_DW-1:HALF] : rdata[HALF-1:0];
    s2_present = rdata[0];
    s2_hfn     = rdata[HPA_W-1:PAGE_SHIFT];
    g_present  = word[0];
    g_gfn      = word[GPA_W-1:PAGE_SHIFT];
  end

  assign unused_bits = ^{rdata[MEM_DW-1:HPA_W], rdata[PAGE_SHIFT-1:1], word[PAGE_SHIFT-1:1]};
endmodule

// File: rtl/nxw_walk_ctrl.sv
module nxw_walk_ctrl
  import nxw_pkg::*;
#(
  parameter int HPA_W      = 40,
  parameter int GPA_W      = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                xl_req_valid,
  output logic                                xl_req_ready,
  input  logic [GPA_W-1:0]                    xl_req_gla,
  input  logic [GPA_W-1:0]                    guest_dir_base,
  input  logic [HPA_W-1:0]                    host_map_base,
  input  logic                                map_enable,
  output logic                                xl_rsp_valid,
  input  logic                                xl_rsp_ready,
  output logic                                xl_rsp_fault,
  output logic [2:0]                          xl_rsp_code,
  output logic [HPA_W-1:0]                    xl_rsp_hpa,
  output logic                                rd_req_valid,
  input  logic                                rd_req_ready,
  output logic [HPA_W-1:0]                    rd_req_addr,
  input  logic                                rd_rsp_valid,
  // address generator interface
  output logic [HPA_W-1:0]                    ag_map_base,
  output logic [GPA_W-PAGE_SHIFT-1:0]         ag_gfn,
  output logic [HPA_W-PAGE_SHIFT-1:0]         ag_hfn,
  output logic [(GPA_W-PAGE_SHIFT)/2-1:0]     ag_idx,
  input  logic [HPA_W-1:0]                    ag_s2_addr,
  input  logic [HPA_W-1:0]                    ag_g_addr,
  // entry decoder interface
  input  logic                                dc_s2_present,
  input  logic [HPA_W-PAGE_SHIFT-1:0]         dc_s2_hfn,
  input  logic                                dc_g_present,
  input  logic [GPA_W-PAGE_SHIFT-1:0]         dc_g_gfn
);
  localparam int GFN_W = GPA_W - PAGE_SHIFT;
  localparam int HFN_W = HPA_W - PAGE_SHIFT;
  localparam int IDX_W = GFN_W / 2;
  localparam int HPAD  = HFN_W - GFN_W;

  walk_state_e          state_q;
  logic [1:0]           phase_q;
  logic                 en_q;
  logic [HPA_W-1:0]     base_q;
  logic [GPA_W-1:0]     gla_q;
  logic [GFN_W-1:0]     gfn_q;
  logic [HFN_W-1:0]     hfn_q;
  logic                 fault_q;
  logic [2:0]           code_q;
  logic [HPA_W-1:0]     hpa_q;
  logic                 unused_base_low;

  assign unused_base_low = ^guest_dir_base[PAGE_SHIFT-1:0];

  // datapath towards the address generator
  assign ag_map_base = base_q;
  assign ag_gfn      = gfn_q;
  assign ag_hfn      = hfn_q;
  assign ag_idx      = (phase_q == 2'd0) ? gla_q[GPA_W-1 -: IDX_W] : gla_q[PAGE_SHIFT +: IDX_W];

  // outputs decoded from state flops only
  assign xl_req_ready = (state_q == ST_IDLE);
  assign xl_rsp_valid = (state_q == ST_DONE);
  assign xl_rsp_fault = fault_q;
  assign xl_rsp_code  = code_q;
  assign xl_rsp_hpa   = hpa_q;
  assign rd_req_valid = (state_q == ST_S2_REQ) || (state_q == ST_G_REQ);
  assign rd_req_addr  = (state_q == ST_S2_REQ) ? ag_s2_addr : ag_g_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      phase_q <= 2'd0;
      en_q    <= 1'b0;
      base_q  <= '0;
      gla_q   <= '0;
      gfn_q   <= '0;
      hfn_q   <= '0;
      fault_q <= 1'b0;
      code_q  <= FC_NONE;
      hpa_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (xl_req_valid) begin
            gla_q   <= xl_req_gla;
            en_q    <= map_enable;
            base_q  <= host_map_base;
            gfn_q   <= guest_dir_base[GPA_W-1:PAGE_SHIFT];
            hfn_q   <= {{HPAD{1'b0}}, guest_dir_base[GPA_W-1:PAGE_SHIFT]};
            phase_q <= 2'd0;
            fault_q <= 1'b0;
            code_q  <= FC_NONE;
            hpa_q   <= '0;
            state_q <= map_enable ? ST_S2_REQ : ST_G_REQ;
          end
        end
        ST_S2_REQ: begin
          if (rd_req_ready) state_q <= ST_S2_WAIT;
        end
        ST_S2_WAIT: begin
          if (rd_rsp_valid) begin
            if (!dc_s2_present) begin
              fault_q <= 1'b1;
              code_q  <= s2_fault_code(phase_q);
              state_q <= ST_DONE;
            end else if (phase_q == 2'd2) begin
              hpa_q   <= {dc_s2_hfn, gla_q[PAGE_SHIFT-1:0]};
              state_q <= ST_DONE;
            end else begin
              hfn_q   <= dc_s2_hfn;
              state_q <= ST_G_REQ;
            end
          end
        end
        ST_G_REQ: begin
          if (rd_req_ready) state_q <= ST_G_WAIT;
        end
        ST_G_WAIT: begin
          if (rd_rsp_valid) begin
            if (!dc_g_present) begin
              fault_q <= 1'b1;
              code_q  <= guest_fault_code(phase_q);
              state_q <= ST_DONE;
            end else begin
              gfn_q   <= dc_g_gfn;
              hfn_q   <= {{HPAD{1'b0}}, dc_g_gfn};
              if (en_q) begin
                phase_q <= phase_q + 2'd1;
                state_q <= ST_S2_REQ;
              end else if (phase_q == 2'd1) begin
                hpa_q   <= {{HPAD{1'b0}}, dc_g_gfn, gla_q[PAGE_SHIFT-1:0]};
                state_q <= ST_DONE;
              end else begin
                phase_q <= 2'd1;
                state_q <= ST_G_REQ;
              end
            end
          end
        end
        ST_DONE: begin
          if (xl_rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nested_xlate_walker.sv
module nested_xlate_walker #(
  parameter int HPA_W      = 40,
  parameter int GPA_W      = 32,
  parameter int PAGE_SHIFT = 12,
  parameter int MEM_DW     = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                xl_req_valid,
  output logic                xl_req_ready,
  input  logic [GPA_W-1:0]    xl_req_gla,
  input  logic [GPA_W-1:0]    guest_dir_base,
  input  logic [HPA_W-1:0]    host_map_base,
  input  logic                map_enable,
  output logic                xl_rsp_valid,
  input  logic                xl_rsp_ready,
  output logic                xl_rsp_fault,
  output logic [2:0]          xl_rsp_code,
  output logic [HPA_W-1:0]    xl_rsp_hpa,
  output logic                rd_req_valid,
  input  logic                rd_req_ready,
  output logic [HPA_W-1:0]    rd_req_addr,
  input  logic                rd_rsp_valid,
  input  logic [MEM_DW-1:0]   rd_rsp_data
);
  localparam int GFN_W = GPA_W - PAGE_SHIFT;
  localparam int HFN_W = HPA_W - PAGE_SHIFT;
  localparam int IDX_W = GFN_W / 2;

  logic [HPA_W-1:0] ag_map_base;
  logic [GFN_W-1:0] ag_gfn;
  logic [HFN_W-1:0] ag_hfn;
  logic [IDX_W-1:0] ag_idx;
  logic [HPA_W-1:0] ag_s2_addr;
  logic [HPA_W-1:0] ag_g_addr;
  logic             dc_s2_present;
  logic [HFN_W-1:0] dc_s2_hfn;
  logic             dc_g_present;
  logic [GFN_W-1:0] dc_g_gfn;

  nxw_walk_ctrl #(.HPA_W(HPA_W), .GPA_W(GPA_W), .PAGE_SHIFT(PAGE_SHIFT)) i_ctrl (
    .clk(clk), .rst(rst),
    .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready), .xl_req_gla(xl_req_gla),
    .guest_dir_base(guest_dir_base), .host_map_base(host_map_base), .map_enable(map_enable),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready), .xl_rsp_fault(xl_rsp_fault),
    .xl_rsp_code(xl_rsp_code), .xl_rsp_hpa(xl_rsp_hpa),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid),
    .ag_map_base(ag_map_base), .ag_gfn(ag_gfn), .ag_hfn(ag_hfn), .ag_idx(ag_idx),
    .ag_s2_addr(ag_s2_addr), .ag_g_addr(ag_g_addr),
    .dc_s2_present(dc_s2_present), .dc_s2_hfn(dc_s2_hfn),
    .dc_g_present(dc_g_present), .dc_g_gfn(dc_g_gfn)
  );

  nxw_addr_gen #(.HPA_W(HPA_W), .GPA_W(GPA_W), .PAGE_SHIFT(PAGE_SHIFT)) i_agen (
    .map_base(ag_map_base), .gfn(ag_gfn), .hfn(ag_hfn), .idx(ag_idx),
    .s2_addr(ag_s2_addr), .g_addr(ag_g_addr)
  );

  nxw_entry_dec #(.HPA_W(HPA_W), .GPA_W(GPA_W), .PAGE_SHIFT(PAGE_SHIFT), .MEM_DW(MEM_DW)) i_dec (
    .rdata(rd_rsp_data), .lane_hi(ag_g_addr[2]),
    .s2_present(dc_s2_present), .s2_hfn(dc_s2_hfn),
    .g_present(dc_g_present), .g_gfn(dc_g_gfn)
  );
endmodule

// File: rtl/nxw_checker.sv
module nxw_checker #(
  parameter int HPA_W      = 40,
  parameter int PAGE_SHIFT = 12
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  xl_req_valid,
  input logic                  xl_req_ready,
  input logic [PAGE_SHIFT-1:0] gla_off,
  input logic                  map_enable,
  input logic                  xl_rsp_valid,
  input logic                  xl_rsp_ready,
  input logic                  xl_rsp_fault,
  input logic [2:0]            xl_rsp_code,
  input logic [HPA_W-1:0]      xl_rsp_hpa,
  input logic                  rd_req_valid,
  input logic                  rd_req_ready,
  input logic [HPA_W-1:0]      rd_req_addr,
  input logic                  rd_rsp_valid
);
  logic                  outstanding;
  logic [2:0]            reads;
  logic                  cap_en;
  logic [PAGE_SHIFT-1:0] cap_off;
  logic [2:0]            exp_reads;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding <= 1'b0;
      reads       <= 3'd0;
      cap_en      <= 1'b0;
      cap_off     <= '0;
    end else begin
      if (rd_req_valid && rd_req_ready) outstanding <= 1'b1;
      else if (rd_rsp_valid)            outstanding <= 1'b0;
      if (xl_req_valid && xl_req_ready) begin
        reads   <= 3'd0;
        cap_en  <= map_enable;
        cap_off <= gla_off;
      end else if (rd_req_valid && rd_req_ready) begin
        reads <= reads + 3'd1;
      end
    end
  end

  always_comb begin
    case ({xl_rsp_fault, xl_rsp_code})
      4'b0_000: exp_reads = cap_en ? 3'd5 : 3'd2;
      4'b1_100: exp_reads = 3'd1;
      4'b1_010: exp_reads = cap_en ? 3'd2 : 3'd1;
      4'b1_101: exp_reads = 3'd3;
      4'b1_001: exp_reads = cap_en ? 3'd4 : 3'd2;
      4'b1_110: exp_reads = 3'd5;
      default:  exp_reads = 3'd7;
    endcase
  end

  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (xl_req_ready && !xl_rsp_valid && !rd_req_valid)); // R1
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && !xl_rsp_fault) |-> (xl_rsp_hpa[PAGE_SHIFT-1:0] == cap_off)); // R2
  AST_WALK_READS: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && !xl_rsp_fault) |-> (reads == (cap_en ? 3'd5 : 3'd2))); // R4
  AST_FAULT_ZERO_HPA: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && xl_rsp_fault) |-> (xl_rsp_hpa == '0)); // R6
  AST_FAULT_CODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid |-> (exp_reads != 3'd7)); // R6
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && xl_rsp_fault) |-> (reads == exp_reads)); // R7
  AST_NO_READ_AT_RSP: assert property (@(posedge clk) disable iff (rst)
    xl_rsp_valid |-> !rd_req_valid); // R7
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid || xl_rsp_valid) |-> !xl_req_ready); // R9
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    (xl_rsp_valid && !xl_rsp_ready) |=> (xl_rsp_valid && $stable(xl_rsp_hpa) && $stable(xl_rsp_code) && $stable(xl_rsp_fault))); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R10
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    rd_req_valid |-> !outstanding); // R10
endmodule

bind nested_xlate_walker nxw_checker #(.HPA_W(HPA_W), .PAGE_SHIFT(PAGE_SHIFT)) i_nxw_checker (
  .clk(clk), .rst(rst),
  .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready),
  .gla_off(xl_req_gla[PAGE_SHIFT-1:0]), .map_enable(map_enable),
  .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready),
  .xl_rsp_fault(xl_rsp_fault), .xl_rsp_code(xl_rsp_code), .xl_rsp_hpa(xl_rsp_hpa),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .rd_rsp_valid(rd_rsp_valid)
);

// File: tb/test_nested_xlate_walker.sv
`timescale 1ns/1ps
module test_nested_xlate_walker;
  localparam int HPA_W = 40;
  localparam int GPA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              xl_req_valid = 1'b0;
  logic              xl_req_ready;
  logic [GPA_W-1:0]  xl_req_gla = '0;
  logic [GPA_W-1:0]  guest_dir_base = '0;
  logic [HPA_W-1:0]  host_map_base = '0;
  logic              map_enable = 1'b0;
  logic              xl_rsp_valid;
  logic              xl_rsp_ready = 1'b0;
  logic              xl_rsp_fault;
  logic [2:0]        xl_rsp_code;
  logic [HPA_W-1:0]  xl_rsp_hpa;
  logic              rd_req_valid;
  logic              rd_req_ready = 1'b1;
  logic [HPA_W-1:0]  rd_req_addr;
  logic              rd_rsp_valid = 1'b0;
  logic [63:0]       rd_rsp_data = '0;

  int checks = 0;
  int fails  = 0;

  // memory model
  logic [63:0]      mem [logic [HPA_W-1:0]];
  logic [HPA_W-1:0] rlog [16];
  int               rlog_n = 0;
  int               stall_mode = 0;
  int               latency = 0;
  int               stall_ctr = 0;
  logic             fire_pend = 1'b0;
  logic             busy = 1'b0;
  int               cnt = 0;
  logic [HPA_W-1:0] cur_addr = '0;

  localparam logic [HPA_W-1:0] MAPB = 40'h00_0800_0000;

  always #2.5 clk = ~clk;

  nested_xlate_walker i_nested_xlate_walker (
    .clk(clk), .rst(rst),
    .xl_req_valid(xl_req_valid), .xl_req_ready(xl_req_ready), .xl_req_gla(xl_req_gla),
    .guest_dir_base(guest_dir_base), .host_map_base(host_map_base), .map_enable(map_enable),
    .xl_rsp_valid(xl_rsp_valid), .xl_rsp_ready(xl_rsp_ready), .xl_rsp_fault(xl_rsp_fault),
    .xl_rsp_code(xl_rsp_code), .xl_rsp_hpa(xl_rsp_hpa),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data)
  );

  function automatic logic [63:0] mem_rd(input logic [HPA_W-1:0] a);
    logic [HPA_W-1:0] k;
    k = {a[HPA_W-1:3], 3'b000};
    return mem.exists(k) ? mem[k] : 64'd0;
  endfunction

  task automatic g_set(input logic [HPA_W-1:0] a, input logic [31:0] v);
    logic [HPA_W-1:0] k;
    logic [63:0] w;
    k = {a[HPA_W-1:3], 3'b000};
    w = mem_rd(k);
    if (a[2]) w[63:32] = v; else w[31:0] = v;
    mem[k] = w;
  endtask

  task automatic s2_set(input logic [HPA_W-1:0] base, input logic [19:0] gfn, input logic [27:0] hfn);
    mem[base + {17'd0, gfn, 3'b000}] = {24'd0, hfn, 12'h001};
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (rd_rsp_valid) rd_rsp_valid = 1'b0;
      if (fire_pend) begin fire_pend = 1'b0; busy = 1'b1; cnt = latency; end
      if (busy) begin
        if (cnt == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = mem_rd(cur_addr);
          busy = 1'b0;
        end else cnt--;
      end
      stall_ctr++;
      rd_req_ready = (stall_mode == 0) || (stall_ctr % 3 == 0);
      if (rd_req_valid && rd_req_ready) begin
        fire_pend = 1'b1;
        cur_addr  = rd_req_addr;
        if (rlog_n < 16) rlog[rlog_n] = rd_req_addr;
        rlog_n++;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one translation; optional scrambling of sampled inputs and response back-pressure
  task automatic do_req(input logic [31:0] gla, input logic en, input logic [31:0] root,
                        input logic [HPA_W-1:0] mbase, input int hold, input logic scramble,
                        output logic f, output logic [2:0] c, output logic [HPA_W-1:0] h, output int nr);
    int tmo;
    logic [HPA_W-1:0] h0;
    @(negedge clk);
    guest_dir_base = root; host_map_base = mbase; map_enable = en;
    rlog_n = 0;
    xl_req_gla = gla; xl_req_valid = 1'b1;
    tmo = 0;
    while (!xl_req_ready && tmo < 1000) begin @(negedge clk); tmo++; end
    @(negedge clk);
    xl_req_valid = 1'b0;
    check(xl_req_ready == 1'b0, "R9 ready low after accept", {63'd0, xl_req_ready}, 64'd0);
    if (scramble) begin
      guest_dir_base = 32'h0000_6000; host_map_base = 40'h00_0900_0000; map_enable = ~en;
    end
    tmo = 0;
    while (!xl_rsp_valid && tmo < 1000) begin @(negedge clk); tmo++; end
    if (tmo >= 1000) check(1'b0, "watchdog response", 64'd0, 64'd1);
    h0 = xl_rsp_hpa;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(xl_rsp_valid && xl_rsp_hpa == h0 && !xl_req_ready, "R9 response held",
            {23'd0, xl_rsp_valid, xl_rsp_hpa}, {23'd0, 1'b1, h0});
    end
    f = xl_rsp_fault; c = xl_rsp_code; h = xl_rsp_hpa; nr = rlog_n;
    xl_rsp_ready = 1'b1;
    @(negedge clk);
    xl_rsp_ready = 1'b0;
    check(xl_rsp_valid == 1'b0 && xl_req_ready == 1'b1, "R9 idle after take",
          {62'd0, xl_rsp_valid, xl_req_ready}, 64'd1);
  endtask

  task automatic t_reset();
    check(xl_req_ready == 1'b1, "R1 req_ready", {63'd0, xl_req_ready}, 64'd1);
    check(xl_rsp_valid == 1'b0, "R1 rsp_valid", {63'd0, xl_rsp_valid}, 64'd0);
    check(rd_req_valid == 1'b0, "R1 rd_req_valid", {63'd0, rd_req_valid}, 64'd0);
  endtask

  task automatic build_tables();
    s2_set(MAPB, 20'h00005, 28'h0012345);
    g_set(40'h00_1234_5004, 32'h0000_7001);
    s2_set(MAPB, 20'h00007, 28'h00ABCDE);
    g_set(40'h00_ABCD_E00C, 32'h0009_9001);
    s2_set(MAPB, 20'h00099, 28'h0030000);
    g_set(40'h00_1234_5010, 32'h0006_6001);
    g_set(40'h00_ABCD_E018, 32'h0004_4001);
    // same guest table reached directly when the map is off
    g_set(40'h00_0000_5004, 32'h0000_7001);
    g_set(40'h00_0000_700C, 32'h0009_9001);
  endtask

  task automatic t_map_on();
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    do_req(32'h0040_3ABC, 1'b1, 32'h0000_5000, MAPB, 0, 1'b0, f, c, h, nr);
    check(!f && c == 3'b000, "R6 success code", {60'd0, f, c}, 64'd0);
    check(h == 40'h00_3000_0ABC, "R4 nested hpa", {24'd0, h}, 64'h3000_0ABC);
    check(nr == 5, "R4 read count", nr, 5);
    check(rlog[0] == 40'h00_0800_0028, "R3 map(root) addr", {24'd0, rlog[0]}, 64'h0800_0028);
    check(rlog[1] == 40'h00_1234_5004, "R2 directory entry addr", {24'd0, rlog[1]}, 64'h1234_5004);
    check(rlog[2] == 40'h00_0800_0038, "R3 map(table) addr", {24'd0, rlog[2]}, 64'h0800_0038);
    check(rlog[3] == 40'h00_ABCD_E00C, "R2 table entry addr", {24'd0, rlog[3]}, 64'hAB_CDE0_0C);
    check(rlog[4] == 40'h00_0800_04C8, "R3 map(data) addr", {24'd0, rlog[4]}, 64'h0800_04C8);
  endtask

  task automatic t_map_off();
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    do_req(32'h0040_3ABC, 1'b0, 32'h0000_5000, MAPB, 0, 1'b0, f, c, h, nr);
    check(!f && h == 40'h00_0009_9ABC, "R5 direct hpa", {24'd0, h}, 64'h9_9ABC);
    check(nr == 2, "R5 read count", nr, 2);
    check(rlog[0] == 40'h5004 && rlog[1] == 40'h700C, "R5 direct read addrs", {24'd0, rlog[1]}, 64'h700C);
  endtask

  task automatic fault_case(input logic [31:0] gla, input logic en, input logic [HPA_W-1:0] mb,
                            input logic [2:0] ec, input int er, input string tag);
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    do_req(gla, en, 32'h0000_5000, mb, 0, 1'b0, f, c, h, nr);
    check(f && c == ec, {"R6 code ", tag}, {60'd0, f, c}, {60'd0, 1'b1, ec});
    check(h == '0, {"R6 zero hpa ", tag}, {24'd0, h}, 64'd0);
    check(nr == er, {"R7 reads stop ", tag}, nr, er);
  endtask

  task automatic t_faults();
    fault_case(32'h0040_3ABC, 1'b1, 40'h00_0900_0000, 3'b100, 1, "map root");
    fault_case(32'h0080_0000, 1'b1, MAPB, 3'b010, 2, "guest dir");
    fault_case(32'h0100_0000, 1'b1, MAPB, 3'b101, 3, "map table");
    fault_case(32'h0040_5000, 1'b1, MAPB, 3'b001, 4, "guest table");
    fault_case(32'h0040_6123, 1'b1, MAPB, 3'b110, 5, "map data");
    fault_case(32'h0080_0000, 1'b0, MAPB, 3'b010, 1, "guest dir direct");
    fault_case(32'h0040_5000, 1'b0, MAPB, 3'b001, 2, "guest table direct");
  endtask

  task automatic t_reread();
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    g_set(40'h00_ABCD_E00C, 32'h0009_A001);
    s2_set(MAPB, 20'h0009A, 28'h0040000);
    do_req(32'h0040_3ABC, 1'b1, 32'h0000_5000, MAPB, 0, 1'b0, f, c, h, nr);
    check(!f && h == 40'h00_4000_0ABC, "R8 edited table seen", {24'd0, h}, 64'h4000_0ABC);
    s2_set(MAPB, 20'h00006, 28'h0012346);
    g_set(40'h00_1234_6004, 32'h0000_8001);
    s2_set(MAPB, 20'h00008, 28'h00ABCDF);
    g_set(40'h00_ABCD_F00C, 32'h0009_9001);
    do_req(32'h0040_3ABC, 1'b1, 32'h0000_6000, MAPB, 0, 1'b0, f, c, h, nr);
    check(!f && h == 40'h00_3000_0ABC, "R8 new guest root", {24'd0, h}, 64'h3000_0ABC);
  endtask

  task automatic t_sampled();
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    do_req(32'h0040_3ABC, 1'b1, 32'h0000_5000, MAPB, 0, 1'b1, f, c, h, nr);
    check(!f && h == 40'h00_4000_0ABC, "R8 inputs latched at accept", {24'd0, h}, 64'h4000_0ABC);
    check(nr == 5, "R8 enable latched", nr, 5);
  endtask

  task automatic t_stall();
    logic f; logic [2:0] c; logic [HPA_W-1:0] h; int nr;
    stall_mode = 1; latency = 3;
    do_req(32'h0040_3FFF, 1'b1, 32'h0000_5000, MAPB, 4, 1'b0, f, c, h, nr);
    check(!f && h == 40'h00_4000_0FFF, "R10 stalled walk result", {24'd0, h}, 64'h4000_0FFF);
    check(nr == 5, "R10 one read per handshake", nr, 5);
    check(rlog[3] == 40'h00_ABCD_E00C, "R10 stalled addr", {24'd0, rlog[3]}, 64'hAB_CDE0_0C);
    stall_mode = 0; latency = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    build_tables();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_map_on();
    t_map_off();
    t_faults();
    t_reread();
    t_sampled();
    t_stall();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule